// File: doc/BRIEF.md
# Per-Core Interrupt Candidate Selector

This block is the last stage of interrupt selection for one processor. It holds the pending, enable, active, group and priority state of the 32 private interrupt IDs (software-generated and private peripheral) and scans them serially. It also takes the best candidate found by the shared stage for this processor. The two compete under one rule, and a single registered winner (ID, priority, group) is presented together with an interrupt-request line.

Acknowledge (activate) and end-of-interrupt (deactivate) requests carry an ID and are dispatched by ID class. Private IDs update the local active state. Shared IDs are forwarded as one-cycle pulses to the shared stage. Message-range IDs on activate become a pending-clear pulse toward the message stage. Any change of state starts a fresh selection. Each fresh selection pulses a request so that the shared stage rescans. The winner is registered only once both the private scan and the shared stage have reported done.

Top module: `core_irq_select`

## Requirements
- R1: After reset the winner is none: win_id = 1023, win_prio = 0xFF, win_group = 0, irq = 0. No dispatch pulse and no sh_req is asserted.
- R2: A private ID is a candidate only when it is pending, enabled, not active, and its group (0 or 1) has its bit set in grp_en (bit 0 for group 0, bit 1 for group 1).
- R3: Among all candidates the lowest priority value wins. On equal priority the lower ID wins, so a private ID beats a shared one of equal priority.
- R4: The shared candidate is ignored in these cases: sh_valid is low, its group is disabled, its priority is 0xFF, its ID is below 32, or its ID lies in the special range 1020 to 8191. Shared IDs from 32 to 1019 and IDs of 8192 and above may win.
- R5: An activate request sets win_prio to 0xFF, win_id to 1023 and irq to 0 on the next cycle. A full reselection follows.
- R6: Activate dispatch depends on the ID. An ID below 32 sets its local active bit. An ID from 32 to 1019 gives a one-cycle fwd_act_valid pulse with that ID. An ID of 8192 or above gives a one-cycle msg_clr_valid pulse with that ID. An ID from 1020 to 8191 gives no pulse.
- R7: Deactivate dispatch depends on the ID. An ID below 32 clears its active bit. An ID from 32 to 1019 gives a one-cycle fwd_deact_valid pulse with that ID. Any other ID only starts a reselection.
- R8: The following each restart the selection, with sh_req high on the next cycle: a pending write, a config write, an activate, a deactivate, or a change of grp_en. The winner is registered 33 cycles after the triggering edge. If sh_done comes later, the winner is registered on the edge after the edge that sampled sh_done.
- R9: irq is high exactly when win_prio is not 0xFF.
- R10: An activate and a deactivate of the same private ID in one cycle leave that ID active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| grp_en | input | 2 | Group enables (bit g enables group g) |
| pend_valid | input | 1 | Private pending write strobe |
| pend_id | input | 5 | Private ID for the pending write |
| pend_set | input | 1 | 1 sets pending, 0 clears it |
| cfg_valid | input | 1 | Private config write strobe |
| cfg_id | input | 5 | Private ID for the config write |
| cfg_enable | input | 1 | Enable bit to write |
| cfg_group | input | 1 | Group to write |
| cfg_prio | input | 8 | Priority to write |
| act_valid | input | 1 | Activate request |
| act_id | input | 14 | ID to activate |
| deact_valid | input | 1 | Deactivate request |
| deact_id | input | 14 | ID to deactivate |
| sh_req | output | 1 | Rescan request to the shared stage |
| sh_done | input | 1 | Shared stage scan finished; candidate valid this cycle |
| sh_valid | input | 1 | Shared stage has a candidate |
| sh_id | input | 14 | Shared candidate ID |
| sh_prio | input | 8 | Shared candidate priority |
| sh_group | input | 1 | Shared candidate group |
| fwd_act_valid | output | 1 | Forwarded activate pulse |
| fwd_act_id | output | 14 | Forwarded activate ID |
| fwd_deact_valid | output | 1 | Forwarded deactivate pulse |
| fwd_deact_id | output | 14 | Forwarded deactivate ID |
| msg_clr_valid | output | 1 | Message-range pending-clear pulse |
| msg_clr_id | output | 14 | Message-range ID to clear |
| win_id | output | 14 | Winning ID (1023 when none) |
| win_prio | output | 8 | Winning priority (0xFF when none) |
| win_group | output | 1 | Winning group |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Two pairs of events are driven into the same clock cycle on purpose. In the first pair, an activate and a deactivate of one private ID arrive together; afterwards the winner must still skip that ID. In the second pair, an activate coincides with a pending write; the very next cycle must show priority 0xFF, and after the rescan the newly pending ID must be the winner. A behavioural model in the bench tracks every state change and the completion timing of both scans. Every output is compared with the model on every clock, so a late, early or lost winner update is reported.

// File: rtl/core_irq_select.sv
module core_irq_select #(
  parameter int NPRIV    = 32,
  parameter int PW       = 8,
  parameter int IW       = 14,
  parameter int SPEC_LO  = 1020,
  parameter int MSG_BASE = 8192,
  parameter int NONE_ID  = 1023
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    grp_en,
  input  logic          pend_valid,
  input  logic [$clog2(NPRIV)-1:0] pend_id,
  input  logic          pend_set,
  input  logic          cfg_valid,
  input  logic [$clog2(NPRIV)-1:0] cfg_id,
  input  logic          cfg_enable,
  input  logic          cfg_group,
  input  logic [PW-1:0] cfg_prio,
  input  logic          act_valid,
  input  logic [IW-1:0] act_id,
  input  logic          deact_valid,
  input  logic [IW-1:0] deact_id,
  output logic          sh_req,
  input  logic          sh_done,
  input  logic          sh_valid,
  input  logic [IW-1:0] sh_id,
  input  logic [PW-1:0] sh_prio,
  input  logic          sh_group,
  output logic          fwd_act_valid,
  output logic [IW-1:0] fwd_act_id,
  output logic          fwd_deact_valid,
  output logic [IW-1:0] fwd_deact_id,
  output logic          msg_clr_valid,
  output logic [IW-1:0] msg_clr_id,
  output logic [IW-1:0] win_id,
  output logic [PW-1:0] win_prio,
  output logic          win_group,
  output logic          irq
);
  localparam int CW = $clog2(NPRIV);
  localparam logic [PW-1:0] IDLE = '1;
  localparam logic [IW-1:0] PRIV_END = IW'(NPRIV);
  localparam logic [IW-1:0] SPEC_START = IW'(SPEC_LO);
  localparam logic [IW-1:0] MSG_START = IW'(MSG_BASE);
  localparam logic [IW-1:0] NOID = IW'(NONE_ID);

  logic [NPRIV-1:0] pend_q, en_q, act_q, grp_q;
  logic [PW-1:0]    prio_q [NPRIV];
  logic [1:0]       grp_en_q;
  logic [CW-1:0]    cnt;
  logic             run, pdone, shseen;
  logic [PW-1:0]    best_prio;
  logic [CW-1:0]    best_id;
  logic             best_grp;
  logic             shv_q, shg_q;
  logic [IW-1:0]    shid_q;
  logic [PW-1:0]    shp_q;

  wire act_priv  = act_valid && act_id < PRIV_END;
  wire act_sh    = act_valid && act_id >= PRIV_END && act_id < SPEC_START;
  wire act_msg   = act_valid && act_id >= MSG_START;
  wire deact_priv = deact_valid && deact_id < PRIV_END;
  wire deact_sh  = deact_valid && deact_id >= PRIV_END && deact_id < SPEC_START;
  wire trig = pend_valid || cfg_valid || act_valid || deact_valid || (grp_en != grp_en_q);

  wire cand = pend_q[cnt] && en_q[cnt] && !act_q[cnt] && grp_en[grp_q[cnt]] &&
              (prio_q[cnt] < best_prio);

  wire sh_special = shid_q >= SPEC_START && shid_q < MSG_START;
  wire sh_ok = shv_q && grp_en[shg_q] && shid_q >= PRIV_END && !sh_special && shp_q != IDLE;
  wire [IW-1:0] best_id_w = {{(IW-CW){1'b0}}, best_id};
  wire sh_wins = sh_ok && (shp_q < best_prio || (shp_q == best_prio && shid_q < best_id_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; en_q <= '0; act_q <= '0; grp_q <= '0;
      for (int i = 0; i < NPRIV; i++) prio_q[i] <= IDLE;
    end else begin
      if (pend_valid) pend_q[pend_id] <= pend_set;
      if (cfg_valid) begin
        en_q[cfg_id]   <= cfg_enable;
        grp_q[cfg_id]  <= cfg_group;
        prio_q[cfg_id] <= cfg_prio;
      end
      if (deact_priv) act_q[deact_id[CW-1:0]] <= 1'b0;
      if (act_priv)   act_q[act_id[CW-1:0]]   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_act_valid <= 1'b0; fwd_act_id <= '0;
      fwd_deact_valid <= 1'b0; fwd_deact_id <= '0;
      msg_clr_valid <= 1'b0; msg_clr_id <= '0;
    end else begin
      fwd_act_valid   <= act_sh;
      fwd_deact_valid <= deact_sh;
      msg_clr_valid   <= act_msg;
      if (act_sh)   fwd_act_id   <= act_id;
      if (deact_sh) fwd_deact_id <= deact_id;
      if (act_msg)  msg_clr_id   <= act_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shv_q <= 1'b0; shid_q <= '0; shp_q <= IDLE; shg_q <= 1'b0;
    end else if (sh_done) begin
      shv_q <= sh_valid; shid_q <= sh_id; shp_q <= sh_prio; shg_q <= sh_group;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en_q <= '0;
      cnt <= '0; run <= 1'b0; pdone <= 1'b0; shseen <= 1'b0; sh_req <= 1'b0;
      best_prio <= IDLE; best_id <= '0; best_grp <= 1'b0;
      win_id <= NOID; win_prio <= IDLE; win_group <= 1'b0; irq <= 1'b0;
    end else begin
      grp_en_q <= grp_en;
      if (trig) begin
        cnt <= '0; run <= 1'b1; pdone <= 1'b0; shseen <= 1'b0; sh_req <= 1'b1;
        best_prio <= IDLE; best_id <= '0; best_grp <= 1'b0;
        if (act_valid) begin
          win_prio <= IDLE; win_id <= NOID; irq <= 1'b0;
        end
      end else begin
        sh_req <= 1'b0;
        if (pdone && shseen) begin
          pdone <= 1'b0; shseen <= 1'b0;
          if (sh_wins) begin
            win_id <= shid_q; win_prio <= shp_q; win_group <= shg_q; irq <= 1'b1;
          end else if (best_prio != IDLE) begin
            win_id <= best_id_w; win_prio <= best_prio; win_group <= best_grp; irq <= 1'b1;
          end else begin
            win_id <= NOID; win_prio <= IDLE; win_group <= 1'b0; irq <= 1'b0;
          end
        end
        if (run) begin
          if (cand) begin
            best_prio <= prio_q[cnt]; best_id <= cnt; best_grp <= grp_q[cnt];
          end
          if (cnt == CW'(NPRIV - 1)) begin
            run <= 1'b0; pdone <= 1'b1;
          end
          cnt <= cnt + 1'b1;
        end
        if (sh_done) shseen <= 1'b1;
      end
    end
  end

  p_act_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> (win_prio == IDLE && !irq && win_id == NOID));
  p_act_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_priv |=> act_q[$past(act_id[CW-1:0])]);
  p_deact_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_priv && !(act_valid && act_id == deact_id)) |=> !act_q[$past(deact_id[CW-1:0])]);
  p_fwd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_act_valid |-> (fwd_act_id >= PRIV_END && fwd_act_id < SPEC_START));
  p_msg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_clr_valid |-> msg_clr_id >= MSG_START);
  p_dispatch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_act_valid, msg_clr_valid}));
  p_no_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !(win_id >= SPEC_START && win_id < MSG_START));
  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (win_prio != IDLE));
  p_rescan_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> sh_req);
endmodule

// File: tb/core_irq_select_test.sv
module core_irq_select_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] grp_en = 2'b11;
  logic pend_valid = 0, pend_set = 0;
  logic [4:0] pend_id = 0;
  logic cfg_valid = 0, cfg_enable = 0, cfg_group = 0;
  logic [4:0] cfg_id = 0;
  logic [7:0] cfg_prio = 0;
  logic act_valid = 0, deact_valid = 0;
  logic [13:0] act_id = 0, deact_id = 0;
  logic sh_done = 0, sh_valid = 0, sh_group = 0;
  logic [13:0] sh_id = 0;
  logic [7:0] sh_prio = 8'hFF;
  logic sh_req, fwd_act_valid, fwd_deact_valid, msg_clr_valid, win_group, irq;
  logic [13:0] fwd_act_id, fwd_deact_id, msg_clr_id, win_id;
  logic [7:0] win_prio;

  core_irq_select uut (
    .clk(clk), .rst_n(rst_n), .grp_en(grp_en),
    .pend_valid(pend_valid), .pend_id(pend_id), .pend_set(pend_set),
    .cfg_valid(cfg_valid), .cfg_id(cfg_id), .cfg_enable(cfg_enable),
    .cfg_group(cfg_group), .cfg_prio(cfg_prio),
    .act_valid(act_valid), .act_id(act_id),
    .deact_valid(deact_valid), .deact_id(deact_id),
    .sh_req(sh_req), .sh_done(sh_done), .sh_valid(sh_valid), .sh_id(sh_id),
    .sh_prio(sh_prio), .sh_group(sh_group),
    .fwd_act_valid(fwd_act_valid), .fwd_act_id(fwd_act_id),
    .fwd_deact_valid(fwd_deact_valid), .fwd_deact_id(fwd_deact_id),
    .msg_clr_valid(msg_clr_valid), .msg_clr_id(msg_clr_id),
    .win_id(win_id), .win_prio(win_prio), .win_group(win_group), .irq(irq));

  int checks = 0, errors = 0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // behavioural reference
  bit m_pend[32], m_en[32], m_act[32], m_grp[32];
  int m_prio[32];
  int m_pcnt, e_id, e_prio, e_grp, e_irq, e_req, e_fa, e_faid, e_fd, e_fdid, e_mc, e_mcid;
  bit m_pd, m_ss, m_shv, m_shg;
  int m_shid, m_shp;
  logic [1:0] m_gq;

  task automatic model_reset();
    foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; m_act[i] = 0; m_grp[i] = 0; m_prio[i] = 255; end
    m_pcnt = 0; m_pd = 0; m_ss = 0; m_shv = 0; m_shg = 0; m_shid = 0; m_shp = 255; m_gq = 0;
    e_id = 1023; e_prio = 255; e_grp = 0; e_irq = 0; e_req = 0;
    e_fa = 0; e_faid = 0; e_fd = 0; e_fdid = 0; e_mc = 0; e_mcid = 0;
  endtask

  task automatic model_select();
    int bp, bi, bg;
    bit ok;
    bp = 255; bi = 1023; bg = 0;
    for (int i = 0; i < 32; i++)
      if (m_pend[i] && m_en[i] && !m_act[i] && grp_en[m_grp[i]] && m_prio[i] < bp) begin
        bp = m_prio[i]; bi = i; bg = m_grp[i];
      end
    ok = m_shv && grp_en[m_shg] && m_shid >= 32 && !(m_shid >= 1020 && m_shid < 8192) && m_shp != 255;
    if (ok && (m_shp < bp || (m_shp == bp && m_shid < bi))) begin
      bp = m_shp; bi = m_shid; bg = m_shg;
    end
    e_id = bi; e_prio = bp; e_grp = (bp == 255) ? 0 : bg; e_irq = (bp != 255);
    if (bp == 255) e_id = 1023;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit trig;
      trig = pend_valid || cfg_valid || act_valid || deact_valid || (grp_en != m_gq);
      e_fa = 0; e_fd = 0; e_mc = 0;
      if (deact_valid) begin
        if (deact_id < 32) m_act[deact_id] = 0;
        else if (deact_id < 1020) begin e_fd = 1; e_fdid = deact_id; end
      end
      if (act_valid) begin
        if (act_id < 32) m_act[act_id] = 1;
        else if (act_id < 1020) begin e_fa = 1; e_faid = act_id; end
        else if (act_id >= 8192) begin e_mc = 1; e_mcid = act_id; end
      end
      if (pend_valid) m_pend[pend_id] = pend_set;
      if (cfg_valid) begin m_en[cfg_id] = cfg_enable; m_grp[cfg_id] = cfg_group; m_prio[cfg_id] = cfg_prio; end
      if (trig) begin
        m_pcnt = 32; m_pd = 0; m_ss = 0; e_req = 1;
        if (act_valid) begin e_prio = 255; e_id = 1023; e_irq = 0; end
      end else begin
        e_req = 0;
        if (m_pd && m_ss) begin model_select(); m_pd = 0; m_ss = 0; end
        if (m_pcnt > 0) begin m_pcnt--; if (m_pcnt == 0) m_pd = 1; end
        if (sh_done) m_ss = 1;
      end
      if (sh_done) begin m_shv = sh_valid; m_shid = sh_id; m_shp = sh_prio; m_shg = sh_group; end
      m_gq = grp_en;
    end
  end

  // every-clock comparison (R8 timing, R9 irq)
  always @(negedge clk) if (rst_n) begin
    chk("R8 model win_id", win_id, e_id);
    chk("R8 model win_prio", win_prio, e_prio);
    chk("R8 model win_group", win_group, e_grp);
    chk("R9 model irq", irq, e_irq);
    chk("R8 model sh_req", sh_req, e_req);
    chk("R6 model fwd_act_valid", fwd_act_valid, e_fa);
    if (e_fa) chk("R6 model fwd_act_id", fwd_act_id, e_faid);
    chk("R7 model fwd_deact_valid", fwd_deact_valid, e_fd);
    if (e_fd) chk("R7 model fwd_deact_id", fwd_deact_id, e_fdid);
    chk("R6 model msg_clr_valid", msg_clr_valid, e_mc);
    if (e_mc) chk("R6 model msg_clr_id", msg_clr_id, e_mcid);
  end

  // shared-stage responder
  int sh_lat = 3, sh_cd = -1;
  always @(negedge clk) begin
    sh_done = (sh_cd == 0);
    if (sh_cd >= 0) sh_cd--;
    if (rst_n && sh_req) sh_cd = sh_lat;
  end

  task automatic cfg(input int id, input bit en, input bit g, input int p);
    @(negedge clk);
    cfg_valid = 1; cfg_id = id; cfg_enable = en; cfg_group = g; cfg_prio = p;
    @(negedge clk);
    cfg_valid = 0;
  endtask
  task automatic pend(input int id, input bit s);
    @(negedge clk);
    pend_valid = 1; pend_id = id; pend_set = s;
    @(negedge clk);
    pend_valid = 0;
  endtask
  task automatic act(input int id);
    @(negedge clk);
    act_valid = 1; act_id = id;
    @(negedge clk);
    act_valid = 0;
  endtask
  task automatic deact(input int id);
    @(negedge clk);
    deact_valid = 1; deact_id = id;
    @(negedge clk);
    deact_valid = 0;
  endtask
  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic kick();
    cfg(31, 0, 0, 8'h80);
    settle(45);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset win_id", win_id, 1023);
    chk("R1 reset win_prio", win_prio, 255);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset sh_req", sh_req, 0);
    rst_n = 1;
    settle(45);
    cfg(5, 1, 0, 8'h40);
    cfg(9, 1, 1, 8'h40);
    cfg(12, 0, 0, 8'h10);
    cfg(20, 1, 1, 8'h08);
    pend(5, 1); pend(9, 1); pend(12, 1);
    settle(45);
    chk("R2 R3 disabled skipped, tie to lower id", win_id, 5);
    chk("R9 irq with winner", irq, 1);
    @(negedge clk); grp_en = 2'b10;
    settle(45);
    chk("R2 R8 group0 disabled", win_id, 9);
    chk("R2 winner group", win_group, 1);
    @(negedge clk); grp_en = 2'b11;
    settle(45);
    chk("R8 group restored", win_id, 5);

    sh_valid = 1; sh_id = 100; sh_prio = 8'h20; sh_group = 0;
    kick();
    chk("R3 shared lower prio wins", win_id, 100);
    sh_id = 2000; sh_prio = 8'h01; kick();
    chk("R4 special id ignored", win_id, 5);
    sh_id = 9000; sh_prio = 8'h30; kick();
    chk("R4 message id may win", win_id, 9000);
    sh_id = 40; sh_prio = 8'h40; kick();
    chk("R3 tie private beats shared", win_id, 5);
    sh_id = 100; sh_prio = 8'h20; kick();
    chk("R3 shared winner again", win_id, 100);

    sh_valid = 0;
    act(100);
    chk("R5 prio dropped after activate", win_prio, 255);
    chk("R5 irq dropped after activate", irq, 0);
    chk("R6 shared activate forwarded", fwd_act_valid, 1);
    chk("R6 forwarded id", fwd_act_id, 100);
    settle(45);
    chk("R5 recompute after activate", win_id, 5);
    act(5);
    settle(45);
    chk("R6 private active blocks", win_id, 9);
    act(9000);
    chk("R6 message activate clears pending", msg_clr_valid, 1);
    chk("R6 message id", msg_clr_id, 9000);
    settle(45);
    act(1500);
    chk("R6 special no forward", fwd_act_valid, 0);
    chk("R6 special no msg clear", msg_clr_valid, 0);
    settle(45);
    deact(5);
    settle(45);
    chk("R7 private deactivate", win_id, 5);
    deact(100);
    chk("R7 shared deactivate forwarded", fwd_deact_valid, 1);
    chk("R7 forwarded deact id", fwd_deact_id, 100);
    settle(45);

    @(negedge clk);
    act_valid = 1; act_id = 9; deact_valid = 1; deact_id = 9;
    @(negedge clk);
    act_valid = 0; deact_valid = 0;
    settle(45);
    act(5);
    settle(45);
    chk("R10 same-cycle act/deact leaves active", irq, 0);
    chk("R10 no winner", win_id, 1023);

    @(negedge clk);
    act_valid = 1; act_id = 1500; pend_valid = 1; pend_id = 20; pend_set = 1;
    @(negedge clk);
    act_valid = 0; pend_valid = 0;
    chk("R5 drop with concurrent pend", win_prio, 255);
    settle(45);
    chk("R2 newly pending wins", win_id, 20);

    sh_lat = 40; sh_valid = 1; sh_id = 50; sh_prio = 8'h01;
    cfg(31, 0, 0, 8'h80);
    settle(36);
    chk("R8 waits for slow shared stage", win_id, 20);
    settle(10);
    chk("R8 slow shared result", win_id, 50);
    pend(20, 0);
    settle(45);
    chk("R3 shared remains", win_id, 50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule